// File: doc/BRIEF.md
# Streaming Morphological Dilation Filter

This block applies grey-level dilation to a pixel stream in raster order. It takes one pixel per clock. Each output sample is the largest value inside a small window centred on the matching input pixel. Only the window positions switched on by a loadable shape mask take part. A pixel carries one or three 8-bit unsigned lanes, and each lane is dilated on its own. The previous image rows are kept in on-chip line memories. Any window position that falls outside the picture reads as zero.

A frame begins with a pixel flagged `in_sof`. On that cycle the block latches the picture width and height from its configuration inputs and takes the shape mask from a shadow copy. It then walks an extended raster. This raster has extra column slots at the end of each row and extra rows after the last row. In those slots no input is taken and zeros are fed in. The result is exactly one output per input pixel, in input order, with start-of-frame and end-of-row flags. Both streams use a valid/ready handshake. Shape-mask entries are written one byte at a time. An entry is enabled when its byte is nonzero.

Top module: `morph_dilate`

## Requirements
- R1: Each output lane equals the maximum of the enabled window positions for that lane. Mask entry index = window_row*K_COLS + window_col. Row 0 is the top row of the window, column 0 is its left column, and the output pixel sits at (K_ROWS/2, K_COLS/2).
- R2: Writing a byte with `mask_wr` high sets mask entry `mask_addr`. The entry is enabled when the byte is nonzero and disabled when it is zero. After reset every entry is enabled, which gives a full rectangle.
- R3: Window positions above, below, left of or right of the picture read as 0. This also holds for a 1x1 picture, for rows of width 1 and for a single row.
- R4: With three lanes, lane n sits at bits [8n+7:8n] of a pixel. Each lane's maximum is taken apart from the other lanes, and the result is put back in the same lane.
- R5: Each frame produces exactly width*height outputs in raster order. `out_sof` is high only on the first output. `out_eol` is high on the output at the last column of each row.
- R6: A frame starts when a valid pixel with `in_sof` is presented while idle. `cfg_width` and `cfg_height` are sampled on that cycle. While idle, pixels without `in_sof` are accepted and discarded and have no effect on any output.
- R7: Mask writes change only the shadow copy. A frame uses the mask that was present at its start-of-frame cycle, so a write made during a frame first takes effect in the next frame.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and no further input pixel is accepted.
- R9: After reset `out_valid` is low, and an output appears only while a frame is being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | $clog2(MAX_COLS+K_COLS/2+1) | Picture width in pixels, 1..MAX_COLS |
| cfg_height | input | $clog2(MAX_ROWS+K_ROWS/2+1) | Picture height in rows, 1..MAX_ROWS |
| mask_wr | input | 1 | Shape-mask byte write strobe |
| mask_addr | input | $clog2(K_ROWS*K_COLS) | Mask entry index |
| mask_data | input | 8 | Mask byte; nonzero enables the entry |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_data | input | 8*CHANNELS | Input pixel, lanes packed |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_eol | output | 1 | Output pixel is the last of a row |
| out_data | output | 8*CHANNELS | Dilated pixel, lanes packed |

## Verification
The window function is driven with a full rectangle, a cross, and a lopsided two-entry mask (top-left plus centre). The lopsided mask shows whether the window is mirrored or shifted. A smooth ramp and a scrambled hash pattern show whether the maximum really covers every enabled position. A frame whose lanes rise and fall in opposite directions proves that the lanes are not compared as one packed word. The border cases use frames of all zeros and all 255, a 1x1 picture, a one-pixel-wide column and a single row. These separate correct zero padding from edge replication and from wrap-around. A stalled, sparse stream and a mask change made mid-frame test the handshake and the point at which a new mask takes effect.

// File: rtl/morph_pkg.sv
package morph_pkg;

   localparam int LANE_W = 8;
   localparam logic [LANE_W-1:0] PAD_VALUE = '0;

   // Map a tap given as (rows back, columns back) from the newest sample to
   // its mask entry, with entry 0 at the top-left corner of the window.
   function automatic int mask_pos(input int rows_back, input int cols_back,
                                   input int k_rows, input int k_cols);
      return (k_rows - 1 - rows_back) * k_cols + (k_cols - 1 - cols_back);
   endfunction

endpackage

// File: rtl/dil_linebuf.sv
module dil_linebuf #(
   parameter int DEPTH = 34,
   parameter int DW    = 8,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/dil_wmax.sv
module dil_wmax
   import morph_pkg::*;
#(
   parameter int NTAP  = 9,
   parameter int LANES = 1,
   parameter int LW    = LANE_W
) (
   input  logic [NTAP*LANES*LW-1:0] taps,
   input  logic [NTAP-1:0]          tap_en,
   output logic [LANES*LW-1:0]      peak
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LW-1:0] acc;
      always_comb begin
         acc = PAD_VALUE;
         for (int t = 0; t < NTAP; t++) begin
            if (tap_en[t] && (taps[(t*LANES + l)*LW +: LW] > acc))
               acc = taps[(t*LANES + l)*LW +: LW];
         end
      end
      assign peak[l*LW +: LW] = acc;
   end

endmodule

// File: rtl/morph_dilate.sv
module morph_dilate
   import morph_pkg::*;
#(
   parameter int CHANNELS = 1,
   parameter int K_ROWS   = 3,
   parameter int K_COLS   = 3,
   parameter int MAX_ROWS = 32,
   parameter int MAX_COLS = 32,
   localparam int RH       = K_ROWS / 2,
   localparam int CHF      = K_COLS / 2,
   localparam int NTAP     = K_ROWS * K_COLS,
   localparam int PIX      = CHANNELS * LANE_W,
   localparam int XW       = $clog2(MAX_COLS + CHF + 1),
   localparam int YW       = $clog2(MAX_ROWS + RH + 1),
   localparam int MAW      = $clog2(NTAP),
   localparam int LB_DEPTH = MAX_COLS + CHF
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [XW-1:0]  cfg_width,
   input  logic [YW-1:0]  cfg_height,
   input  logic           mask_wr,
   input  logic [MAW-1:0] mask_addr,
   input  logic [7:0]     mask_data,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic           in_sof,
   input  logic [PIX-1:0] in_data,
   output logic           out_valid,
   input  logic           out_ready,
   output logic           out_sof,
   output logic           out_eol,
   output logic [PIX-1:0] out_data
);

   if ((K_ROWS % 2) == 0 || (K_COLS % 2) == 0 || K_ROWS < 3 || K_COLS < 3) begin : g_bad_kernel
      $error("morph_dilate: window sides must be odd and at least 3");
   end
   if (CHANNELS != 1 && CHANNELS != 3) begin : g_bad_lanes
      $error("morph_dilate: CHANNELS must be 1 or 3");
   end
   if (MAX_ROWS < 1 || MAX_COLS < 1) begin : g_bad_size
      $error("morph_dilate: picture limits must be positive");
   end

   // frame state
   logic            active_q, first_q;
   logic [XW-1:0]   wid_q, col_c;
   logic [YW-1:0]   hei_q, row_r;
   logic [NTAP-1:0] msk_sh, msk_act;

   // datapath
   logic [PIX-1:0]      col_v [K_ROWS];
   logic [PIX-1:0]      lb_rd [K_ROWS-1];
   logic [PIX-1:0]      col_q [K_COLS-1][K_ROWS];
   logic [NTAP*PIX-1:0] taps_flat;
   logic [NTAP-1:0]     tap_en;
   logic [PIX-1:0]      peak;

   logic need_in, emit, out_free, step, last_col, last_row, start;

   assign need_in  = (row_r < hei_q) && (col_c < wid_q);
   assign emit     = (row_r >= YW'(RH)) && (col_c >= XW'(CHF));
   assign out_free = !out_valid || out_ready;
   assign step     = active_q && out_free && (!need_in || in_valid);
   assign last_col = (col_c == wid_q + XW'(CHF) - XW'(1));
   assign last_row = (row_r == hei_q + YW'(RH) - YW'(1));
   assign start    = !active_q && in_valid && in_sof;
   assign in_ready = active_q ? (need_in && out_free) : !in_sof;

   // newest column: live sample on top, older rows from the line memories
   assign col_v[0] = need_in ? in_data : {CHANNELS{PAD_VALUE}};
   for (genvar k = 1; k < K_ROWS; k++) begin : g_vert
      assign col_v[k] = (row_r >= YW'(k)) ? lb_rd[k-1] : {CHANNELS{PAD_VALUE}};
      dil_linebuf #(.DEPTH(LB_DEPTH), .DW(PIX), .AW(XW)) u_lb (
         .clk   (clk),
         .we    (step),
         .addr  (col_c),
         .wdata (col_v[k-1]),
         .rdata (lb_rd[k-1])
      );
   end

   always_ff @(posedge clk) begin
      if (step) begin
         for (int k = 0; k < K_ROWS; k++) begin
            col_q[0][k] <= col_v[k];
            for (int j = 1; j < K_COLS-1; j++) col_q[j][k] <= col_q[j-1][k];
         end
      end
   end

   // window taps in mask order; columns left of the picture are disabled
   for (genvar k = 0; k < K_ROWS; k++) begin : g_tr
      for (genvar j = 0; j < K_COLS; j++) begin : g_tc
         localparam int T = mask_pos(k, j, K_ROWS, K_COLS);
         if (j == 0) begin : g_live
            assign taps_flat[T*PIX +: PIX] = col_v[k];
         end else begin : g_held
            assign taps_flat[T*PIX +: PIX] = col_q[j-1][k];
         end
         assign tap_en[T] = msk_act[T] && (col_c >= XW'(j));
      end
   end

   dil_wmax #(.NTAP(NTAP), .LANES(CHANNELS), .LW(LANE_W)) u_wmax (
      .taps   (taps_flat),
      .tap_en (tap_en),
      .peak   (peak)
   );

   // control: extended raster scan and shape mask
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         first_q  <= 1'b0;
         wid_q    <= '0;
         hei_q    <= '0;
         col_c    <= '0;
         row_r    <= '0;
         msk_sh   <= '1;
         msk_act  <= '1;
      end else begin
         if (mask_wr && (int'(mask_addr) < NTAP)) msk_sh[mask_addr] <= |mask_data;
         if (start) begin
            active_q <= 1'b1;
            first_q  <= 1'b1;
            wid_q    <= cfg_width;
            hei_q    <= cfg_height;
            msk_act  <= msk_sh;
            col_c    <= '0;
            row_r    <= '0;
         end else if (step) begin
            if (emit) first_q <= 1'b0;
            if (last_col) begin
               col_c <= '0;
               if (last_row) active_q <= 1'b0;
               else          row_r    <= row_r + YW'(1);
            end else begin
               col_c <= col_c + XW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_data  <= '0;
      end else if (step && emit) begin
         out_valid <= 1'b1;
         out_sof   <= first_q;
         out_eol   <= last_col;
         out_data  <= peak;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/morph_dilate_chk.sv
module morph_dilate_chk #(
   parameter int NTAP = 9,
   parameter int PIX  = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            active,
   input logic [NTAP-1:0] msk_act,
   input logic            in_valid,
   input logic            in_ready,
   input logic            out_valid,
   input logic            out_ready,
   input logic            out_sof,
   input logic [PIX-1:0]  out_data
);

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

   AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
      active && out_valid && !out_ready |-> !in_ready); // R8

   AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      active && $past(active) |-> $stable(msk_act)); // R7

   AST_OUT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(active)); // R9

   AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_sof |=> !(out_valid && out_sof)); // R5

   AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      !active && in_valid && !in_ready |=> active); // R6

endmodule

bind morph_dilate morph_dilate_chk #(.NTAP(NTAP), .PIX(PIX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .active    (active_q),
   .msk_act   (msk_act),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_sof   (out_sof),
   .out_data  (out_data)
);

// File: tb/morph_dilate_bench.sv
module morph_dilate_bench;

   localparam int CH  = 3;
   localparam int KR  = 3;
   localparam int KC  = 3;
   localparam int MR  = 12;
   localparam int MC  = 12;
   localparam int PIX = CH * 8;
   localparam int NT  = KR * KC;
   localparam int XW  = $clog2(MC + KC/2 + 1);
   localparam int YW  = $clog2(MR + KR/2 + 1);
   localparam int MAW = $clog2(NT);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [XW-1:0]  cfg_width = '0;
   logic [YW-1:0]  cfg_height = '0;
   logic           mask_wr = 1'b0;
   logic [MAW-1:0] mask_addr = '0;
   logic [7:0]     mask_data = '0;
   logic           in_valid = 1'b0;
   logic           in_ready;
   logic           in_sof = 1'b0;
   logic [PIX-1:0] in_data = '0;
   logic           out_valid;
   logic           out_ready = 1'b1;
   logic           out_sof;
   logic           out_eol;
   logic [PIX-1:0] out_data;

   morph_dilate #(.CHANNELS(CH), .K_ROWS(KR), .K_COLS(KC),
                  .MAX_ROWS(MR), .MAX_COLS(MC)) u_morph_dilate (
      .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
      .mask_wr(mask_wr), .mask_addr(mask_addr), .mask_data(mask_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_sof(out_sof),
      .out_eol(out_eol), .out_data(out_data)
   );

   always #4 clk = ~clk;

   int unsigned    checks = 0;
   int unsigned    errors = 0;
   int unsigned    cyc = 0;
   int unsigned    rng = 32'h1234_5678;
   logic [PIX-1:0] img [MR][MC];
   bit             ref_mask [NT];

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int kind, input int y, input int x, input int l);
      case (kind)
         0:       return 8'(y*37 + x*11 + l*85);
         1:       return 8'h00;
         2:       return 8'hFF;
         3:       return 8'(((y*53) ^ (x*29)) + l*71 + x*y*7);
         default: return (l == 0) ? 8'(x*20 + y) : (l == 1) ? 8'(y*30) : 8'(255 - x*20 - y);
      endcase
   endfunction

   function automatic logic [PIX-1:0] expect_pix(input int y, input int x, input int w, input int h);
      logic [PIX-1:0] r;
      logic [7:0]     m, v;
      int             sy, sx;
      r = '0;
      for (int l = 0; l < CH; l++) begin
         m = 8'h00;
         for (int dy = 0; dy < KR; dy++) begin
            for (int dx = 0; dx < KC; dx++) begin
               if (ref_mask[dy*KC + dx]) begin
                  sy = y + dy - KR/2;
                  sx = x + dx - KC/2;
                  v = (sy >= 0 && sy < h && sx >= 0 && sx < w) ? img[sy][sx][l*8 +: 8] : 8'h00;
                  if (v > m) m = v;
               end
            end
         end
         r[l*8 +: 8] = m;
      end
      return r;
   endfunction

   task automatic load_mask(input bit [NT-1:0] bits);
      for (int t = 0; t < NT; t++) begin
         @(negedge clk);
         mask_wr   = 1'b1;
         mask_addr = MAW'(t);
         mask_data = bits[t] ? 8'(8'h21 + t*13) : 8'h00;
         ref_mask[t] = bits[t];
      end
      @(negedge clk);
      mask_wr = 1'b0;
   endtask

   // One frame through the block, every output compared against the model.
   task automatic run_frame(input int w, input int h, input int kind, input string req,
                            input bit stall, input bit mid_write);
      int n, i, o, guard, y, x;
      bit held_v, wrote;
      logic [PIX-1:0] held_d, exp_d;
      n = w * h; i = 0; o = 0; guard = 0; held_v = 0; held_d = '0; wrote = 0;
      for (int yy = 0; yy < h; yy++)
         for (int xx = 0; xx < w; xx++)
            for (int l = 0; l < CH; l++) img[yy][xx][l*8 +: 8] = pat(kind, yy, xx, l);
      @(negedge clk);
      cfg_width  = XW'(w);
      cfg_height = YW'(h);
      while (o < n && guard < 4000) begin
         @(negedge clk);
         guard++;
         rng = rng * 1103515245 + 12345;
         in_valid  = (i < n) && (!stall || rng[18]);
         in_sof    = (i == 0);
         in_data   = (i < n) ? img[i / w][i % w] : '0;
         out_ready = !stall || rng[20] || rng[21];
         mask_wr   = 1'b0;
         if (mid_write && !wrote && i == n/2) begin
            mask_wr = 1'b1; mask_addr = MAW'(NT/2); mask_data = 8'h00; wrote = 1;
         end
         #1;
         if (held_v)
            check(out_valid && out_data == held_d, "R8", "held output changed",
                  longint'({out_valid, out_data}), longint'({1'b1, held_d}));
         if (out_valid && out_ready) begin
            y = o / w; x = o % w;
            exp_d = expect_pix(y, x, w, h);
            check(out_data == exp_d && out_sof == (o == 0) && out_eol == (x == w-1), req,
                  $sformatf("pixel y=%0d x=%0d {sof,eol,data}", y, x),
                  longint'({out_sof, out_eol, out_data}),
                  longint'({o == 0, x == w-1, exp_d}));
            o++;
         end
         if (held_v && out_valid && !out_ready)
            check(!in_ready, "R8", "input taken during output stall", in_ready, 0);
         held_v = out_valid && !out_ready;
         held_d = out_data;
         if (in_valid && in_ready) i++;
      end
      in_valid = 1'b0; in_sof = 1'b0; out_ready = 1'b1; mask_wr = 1'b0;
      check(o == n && i == n, "R5", "pixels out/in per frame", o, n);
      repeat (4) @(negedge clk);
      #1;
      check(!out_valid, "R5", "extra output after frame", out_valid, 0);
      if (mid_write) ref_mask[NT/2] = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
      check(in_ready, "R6", "idle in_ready without sof", in_ready, 1);
   endtask

   task automatic t_rect_default;
      for (int t = 0; t < NT; t++) ref_mask[t] = 1'b1;
      run_frame(5, 4, 0, "R2 default rectangle", 0, 0);
   endtask

   task automatic t_shapes;
      load_mask(9'b010_111_010);
      run_frame(6, 5, 3, "R1 cross", 0, 0);
      load_mask(9'b000_010_001);
      run_frame(7, 6, 3, "R1 top-left+centre", 0, 0);
      load_mask(9'b000_000_000);
      run_frame(3, 3, 2, "R2 empty mask", 0, 0);
   endtask

   task automatic t_lanes;
      load_mask(9'b111_111_111);
      run_frame(8, 4, 4, "R4 lanes", 0, 0);
   endtask

   task automatic t_edges;
      load_mask(9'b111_111_111);
      run_frame(1, 1, 3, "R3 single pixel", 0, 0);
      run_frame(1, 6, 0, "R3 width one", 0, 0);
      run_frame(6, 1, 3, "R3 single row", 0, 0);
      run_frame(4, 4, 1, "R3 all zero", 0, 0);
      run_frame(4, 4, 2, "R3 all 255", 0, 0);
      run_frame(MC, 3, 3, "R3 full width", 0, 0);
   endtask

   task automatic t_midload;
      load_mask(9'b111_111_111);
      run_frame(6, 5, 3, "R7 old mask kept", 0, 1);
      run_frame(6, 5, 3, "R7 new mask applied", 0, 0);
   endtask

   task automatic t_stall;
      load_mask(9'b010_111_010);
      run_frame(8, 7, 3, "R8 stalled stream", 1, 0);
   endtask

   task automatic t_idle_junk;
      load_mask(9'b111_111_111);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sof = 1'b0; in_data = '1;
         #1;
         check(in_ready, "R6", "idle junk accepted", in_ready, 1);
         check(!out_valid, "R6", "idle junk gave output", out_valid, 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      run_frame(4, 3, 1, "R6 frame after junk", 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_rect_default();
      t_shapes();
      t_lanes();
      t_edges();
      t_midload();
      t_stall();
      t_idle_junk();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule